// File: doc/BRIEF.md
# DMA Command Issue Sequencer for a Disk Interface Host

This block runs one disk DMA read or DMA write command from start to finish, so the CPU does not have to poll. The CPU supplies a command code and a transfer direction and pulses a start line. The sequencer first reads the device status register. It retries that read at a programmable spacing until the device is ready, or until a programmable number of attempts has been used up. It then writes the command register.

Once the command is written, the sequencer never touches the status register again until the device raises its interrupt line. During this window it watches only the DMA request and interrupt lines. While the device requests DMA, it passes control to a separate burst engine through an enable line. When the interrupt arrives and the burst engine reports idle, it reads status once, latches the byte and a result code, and holds an interrupt to the CPU until the CPU clears it.

The device register bus is a single-cycle strobe bus, and read data is sampled in the same cycle as the read strobe. Burst timing, CRC and the data path belong to the burst engine and are not part of this block.

Top module: `dma_cmd_sequencer`

## Requirements
- R1: After reset, cpu_irq, cpu_busy, dev_rd, dev_wr and burst_en are low, and cpu_status and cpu_result are zero.
- R2: A start is accepted only for code 8'hC8 with cpu_dir=0 (read) or code 8'hCA with cpu_dir=1 (write). Any other pairing raises cpu_irq on the cycle after the start, with cpu_result=3 (bad command) and cpu_status=0, and produces no dev_rd and no dev_wr.
- R3: On the cycle after an accepted start, dev_rd is high with dev_reg_sel=0 (status register). The device counts as ready when bit 7 (busy) is 0, bit 6 (ready) is 1 and bit 3 (data request) is 0. All other bits are ignored. On the cycle after a ready read, dev_wr is high with dev_reg_sel=1 and dev_wdata equal to the command code.
- R4: After a failed readiness read, the next status read strobe comes exactly cfg_poll_gap+2 cycles after the failed one.
- R5: After N failed readiness reads, where N is cfg_max_tries and 0 counts as 1, the block raises cpu_irq with cpu_result=2 (not ready). cpu_status then holds the last byte read, and no command write ever occurs.
- R6: Between a command write and the first cycle in which dev_intrq is seen high, dev_rd stays low.
- R7: burst_en is high exactly when the data phase is active and dev_dmarq is high. burst_dir equals the accepted cpu_dir.
- R8: When dev_intrq is seen with burst_idle high, one status read follows on the next cycle, and cpu_irq rises on the cycle after that. cpu_status holds the byte read. cpu_result is 1 (device error) if bit 0 is set and 0 otherwise. While burst_idle is low, the block issues no read and raises no cpu_irq.
- R9: An interrupt that arrives before any DMA request completes the command the same way, and burst_en never rises.
- R10: If neither dev_dmarq nor dev_intrq is high during the cfg_wdog_limit+1 cycles after the command write cycle, cpu_irq rises cfg_wdog_limit+2 cycles after that write, with cpu_result=4 (timeout) and no further status read. An interrupt on the last of those cycles still completes normally.
- R11: cpu_irq, cpu_status and cpu_result stay unchanged until cpu_clear. A start while cpu_irq is high is ignored. cpu_irq drops on the cycle after cpu_clear.
- R12: cpu_busy is high from the cycle after an accepted start until cpu_irq rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_poll_gap | input | GAP_W | Extra idle cycles between readiness reads |
| cfg_max_tries | input | TRIES_W | Readiness read attempts allowed (0 acts as 1) |
| cfg_wdog_limit | input | WDOG_W | Watchdog window after the command write |
| cpu_start | input | 1 | Start pulse from the CPU |
| cpu_dir | input | 1 | 1 = DMA write, 0 = DMA read |
| cpu_cmd | input | 8 | Command code |
| cpu_clear | input | 1 | Acknowledge and clear the held result |
| cpu_busy | output | 1 | Command in progress |
| cpu_irq | output | 1 | Held completion interrupt |
| cpu_result | output | 3 | 0 ok, 1 device error, 2 not ready, 3 bad command, 4 timeout |
| cpu_status | output | 8 | Last status byte read for this command |
| dev_rd | output | 1 | Register read strobe |
| dev_wr | output | 1 | Register write strobe |
| dev_reg_sel | output | 1 | 0 status register, 1 command register |
| dev_wdata | output | 8 | Write data |
| dev_rdata | input | 8 | Read data, valid in the strobe cycle |
| dev_dmarq | input | 1 | Device DMA request |
| dev_intrq | input | 1 | Device interrupt |
| burst_en | output | 1 | Enable to the burst engine |
| burst_dir | output | 1 | Direction to the burst engine |
| burst_idle | input | 1 | Burst engine reports idle |

## Verification
The bench sweeps all 256 pre-issue status bytes. A readiness test that compared against exact values, or that ignored the data-request bit, would then issue commands it should refuse, or refuse ones it should issue. It sweeps retry counts and spacings, so an off-by-one in either counter shows up as a wrong read count or a wrong strobe distance. It also places an interrupt on the last cycle of the watchdog window. A watchdog that fired one cycle early would turn that good completion into a timeout. Finally, it raises the interrupt while the burst engine is still busy, and before any DMA request. A design that read status too early, or that needed a DMA request before it would finish, would show a stray read or hang.

// File: rtl/ata_dma_seq_pkg.sv
package ata_dma_seq_pkg;

    localparam logic [7:0] CMD_DMA_READ  = 8'hC8;
    localparam logic [7:0] CMD_DMA_WRITE = 8'hCA;

    // readiness: busy(7)=0, ready(6)=1, data request(3)=0
    localparam logic [7:0] READY_MASK  = 8'hC8;
    localparam logic [7:0] READY_VALUE = 8'h40;
    localparam int         ERR_BIT     = 0;

    localparam logic SEL_STATUS  = 1'b0;
    localparam logic SEL_COMMAND = 1'b1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE_RD,
        S_GAP,
        S_ISSUE,
        S_WAIT,
        S_XFER,
        S_FINAL_RD,
        S_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_DEVERR  = 3'd1,
        RES_NOTRDY  = 3'd2,
        RES_BADCMD  = 3'd3,
        RES_TIMEOUT = 3'd4
    } seq_result_e;

endpackage

// File: rtl/ata_cmd_screen.sv
module ata_cmd_screen
    import ata_dma_seq_pkg::*;
(
    input  logic [7:0] code,
    input  logic       dir_write,
    output logic       legal
);
    always_comb begin
        legal = ((code == CMD_DMA_READ)  && !dir_write) ||
                ((code == CMD_DMA_WRITE) &&  dir_write);
    end
endmodule

// File: rtl/ata_status_eval.sv
module ata_status_eval
    import ata_dma_seq_pkg::*;
(
    input  logic [7:0] stat,
    output logic       ready,
    output logic       err
);
    always_comb begin
        ready = ((stat & READY_MASK) == READY_VALUE);
        err   = stat[ERR_BIT];
    end
endmodule

// File: rtl/seq_wait_counter.sv
module seq_wait_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_zero,
    input  logic [W-1:0] limit,
    output logic         at_limit
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hold_zero) begin
            cnt_d = '0;
        end else if (cnt_q != limit) begin
            cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_limit = (cnt_q == limit);
endmodule

// File: rtl/dma_cmd_sequencer.sv
module dma_cmd_sequencer
    import ata_dma_seq_pkg::*;
#(
    parameter int GAP_W   = 8,
    parameter int TRIES_W = 4,
    parameter int WDOG_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GAP_W-1:0]   cfg_poll_gap,
    input  logic [TRIES_W-1:0] cfg_max_tries,
    input  logic [WDOG_W-1:0]  cfg_wdog_limit,
    input  logic               cpu_start,
    input  logic               cpu_dir,
    input  logic [7:0]         cpu_cmd,
    input  logic               cpu_clear,
    output logic               cpu_busy,
    output logic               cpu_irq,
    output logic [2:0]         cpu_result,
    output logic [7:0]         cpu_status,
    output logic               dev_rd,
    output logic               dev_wr,
    output logic               dev_reg_sel,
    output logic [7:0]         dev_wdata,
    input  logic [7:0]         dev_rdata,
    input  logic               dev_dmarq,
    input  logic               dev_intrq,
    output logic               burst_en,
    output logic               burst_dir,
    input  logic               burst_idle
);
    localparam int ATT_W = TRIES_W + 1;

    typedef struct packed {
        seq_state_e         state;
        logic [TRIES_W-1:0] tries;
        logic [7:0]         cmd;
        logic               dir;
        logic [7:0]         status;
        seq_result_e        result;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             cmd_legal;
    logic             dev_ready;
    logic             dev_err;
    logic             gap_hit;
    logic             wdog_hit;
    logic [ATT_W-1:0] attempt;

    ata_cmd_screen u_screen (
        .code      (cpu_cmd),
        .dir_write (cpu_dir),
        .legal     (cmd_legal)
    );

    ata_status_eval u_eval (
        .stat  (dev_rdata),
        .ready (dev_ready),
        .err   (dev_err)
    );

    seq_wait_counter #(.W(GAP_W)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (r_q.state != S_GAP),
        .limit     (cfg_poll_gap),
        .at_limit  (gap_hit)
    );

    seq_wait_counter #(.W(WDOG_W)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (r_q.state != S_WAIT),
        .limit     (cfg_wdog_limit),
        .at_limit  (wdog_hit)
    );

    always_comb begin
        attempt = {1'b0, r_q.tries} + {{TRIES_W{1'b0}}, 1'b1};
        r_d     = r_q;
        unique case (r_q.state)
            S_IDLE: begin
                if (cpu_start) begin
                    r_d.cmd    = cpu_cmd;
                    r_d.dir    = cpu_dir;
                    r_d.status = '0;
                    r_d.tries  = '0;
                    if (cmd_legal) begin
                        r_d.result = RES_OK;
                        r_d.state  = S_PRE_RD;
                    end else begin
                        r_d.result = RES_BADCMD;
                        r_d.state  = S_DONE;
                    end
                end
            end
            S_PRE_RD: begin
                r_d.status = dev_rdata;
                if (dev_ready) begin
                    r_d.state = S_ISSUE;
                end else if (attempt >= {1'b0, cfg_max_tries}) begin
                    r_d.result = RES_NOTRDY;
                    r_d.state  = S_DONE;
                end else begin
                    r_d.tries = attempt[TRIES_W-1:0];
                    r_d.state = S_GAP;
                end
            end
            S_GAP: begin
                if (gap_hit) r_d.state = S_PRE_RD;
            end
            S_ISSUE: begin
                r_d.state = S_WAIT;
            end
            S_WAIT: begin
                if (dev_intrq && burst_idle) begin
                    r_d.state = S_FINAL_RD;
                end else if (dev_intrq || dev_dmarq) begin
                    r_d.state = S_XFER;
                end else if (wdog_hit) begin
                    r_d.result = RES_TIMEOUT;
                    r_d.state  = S_DONE;
                end
            end
            S_XFER: begin
                if (dev_intrq && burst_idle) r_d.state = S_FINAL_RD;
            end
            S_FINAL_RD: begin
                r_d.status = dev_rdata;
                r_d.result = dev_err ? RES_DEVERR : RES_OK;
                r_d.state  = S_DONE;
            end
            S_DONE: begin
                if (cpu_clear) r_d.state = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= S_IDLE;
            r_q.tries  <= '0;
            r_q.cmd    <= '0;
            r_q.dir    <= 1'b0;
            r_q.status <= '0;
            r_q.result <= RES_OK;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        dev_rd      = (r_q.state == S_PRE_RD) || (r_q.state == S_FINAL_RD);
        dev_wr      = (r_q.state == S_ISSUE);
        dev_reg_sel = dev_wr ? SEL_COMMAND : SEL_STATUS;
        dev_wdata   = dev_wr ? r_q.cmd : 8'h00;
        burst_en    = (r_q.state == S_XFER) && dev_dmarq;
        burst_dir   = r_q.dir;
        cpu_busy    = (r_q.state != S_IDLE) && (r_q.state != S_DONE);
        cpu_irq     = (r_q.state == S_DONE);
        cpu_result  = r_q.result;
        cpu_status  = r_q.status;
    end
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dev_rd,
    input logic       dev_wr,
    input logic       dev_reg_sel,
    input logic [7:0] dev_wdata,
    input logic       dev_dmarq,
    input logic       dev_intrq,
    input logic       burst_en,
    input logic       cpu_busy,
    input logic       cpu_irq,
    input logic       cpu_clear,
    input logic [2:0] cpu_result,
    input logic [7:0] cpu_status
);
    logic quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    quiet_q <= 1'b0;
        else if (dev_wr)               quiet_q <= 1'b1;
        else if (dev_intrq || cpu_irq) quiet_q <= 1'b0;
    end

    // R6
    no_status_read_in_data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q |-> !dev_rd);

    // R7
    burst_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_en |-> (dev_dmarq && cpu_busy));

    // R3
    cmd_write_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr |-> (dev_reg_sel && !dev_rd && ((dev_wdata == 8'hC8) || (dev_wdata == 8'hCA))));

    // R3
    read_targets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd |-> !dev_reg_sel);

    // R11
    irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && !cpu_clear) |=> (cpu_irq && $stable(cpu_status) && $stable(cpu_result)));

    // R11
    irq_drops_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && cpu_clear) |=> !cpu_irq);

    // R12
    done_is_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (!cpu_busy && !dev_rd && !dev_wr && !burst_en));
endmodule

bind dma_cmd_sequencer dma_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_rd      (dev_rd),
    .dev_wr      (dev_wr),
    .dev_reg_sel (dev_reg_sel),
    .dev_wdata   (dev_wdata),
    .dev_dmarq   (dev_dmarq),
    .dev_intrq   (dev_intrq),
    .burst_en    (burst_en),
    .cpu_busy    (cpu_busy),
    .cpu_irq     (cpu_irq),
    .cpu_clear   (cpu_clear),
    .cpu_result  (cpu_result),
    .cpu_status  (cpu_status)
);

// File: tb/sim_dma_cmd_sequencer.sv
module sim_dma_cmd_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_poll_gap = 8'd0;
    logic [3:0] cfg_max_tries = 4'd1;
    logic [15:0] cfg_wdog_limit = 16'd50;
    logic       cpu_start = 1'b0;
    logic       cpu_dir = 1'b0;
    logic [7:0] cpu_cmd = 8'h00;
    logic       cpu_clear = 1'b0;
    logic [7:0] dev_status = 8'h00;
    logic       dev_dmarq = 1'b0;
    logic       dev_intrq = 1'b0;
    logic       burst_idle = 1'b1;

    logic       cpu_busy, cpu_irq, dev_rd, dev_wr, dev_reg_sel, burst_en, burst_dir;
    logic [2:0] cpu_result;
    logic [7:0] cpu_status, dev_wdata, dev_rdata;

    assign dev_rdata = dev_status;

    always #5 clk = ~clk;

    dma_cmd_sequencer u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_poll_gap(cfg_poll_gap), .cfg_max_tries(cfg_max_tries), .cfg_wdog_limit(cfg_wdog_limit),
        .cpu_start(cpu_start), .cpu_dir(cpu_dir), .cpu_cmd(cpu_cmd), .cpu_clear(cpu_clear),
        .cpu_busy(cpu_busy), .cpu_irq(cpu_irq), .cpu_result(cpu_result), .cpu_status(cpu_status),
        .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_reg_sel(dev_reg_sel), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .dev_dmarq(dev_dmarq), .dev_intrq(dev_intrq),
        .burst_en(burst_en), .burst_dir(burst_dir), .burst_idle(burst_idle)
    );

    int nchk = 0;
    int nfail = 0;

    // bus monitor
    int cyc = 0, rd_cnt = 0, wr_cnt = 0, last_rd_cyc = 0, last_gap = 0, bad_rd = 0, burst_cyc = 0;
    logic quiet_tb = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (dev_rd) begin
            rd_cnt      <= rd_cnt + 1;
            last_gap    <= cyc - last_rd_cyc;
            last_rd_cyc <= cyc;
            if (quiet_tb) bad_rd <= bad_rd + 1;
        end
        if (dev_wr) quiet_tb <= 1'b1;
        else if (dev_intrq || cpu_irq) quiet_tb <= 1'b0;
        if (dev_wr) wr_cnt <= wr_cnt + 1;
        if (burst_en) burst_cyc <= burst_cyc + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [7:0] code, input logic dir);
        @(negedge clk);
        cpu_cmd   = code;
        cpu_dir   = dir;
        cpu_start = 1'b1;
        @(negedge clk);
        cpu_start = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk);
        cpu_clear = 1'b1;
        @(negedge clk);
        cpu_clear = 1'b0;
        check(!cpu_irq, "R11 irq drops after clear", int'(cpu_irq), 0);
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 400 && !cpu_irq; k++) @(negedge clk);
        check(cpu_irq, "R5/R8 completion interrupt seen", int'(cpu_irq), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!cpu_irq && !cpu_busy, "R1 irq/busy after reset", int'({cpu_irq, cpu_busy}), 0);
        check(!dev_rd && !dev_wr && !burst_en, "R1 strobes after reset", int'({dev_rd, dev_wr, burst_en}), 0);
        check(cpu_status == 8'h00 && cpu_result == 3'd0, "R1 result regs after reset",
              int'({cpu_result, cpu_status}), 0);

        // R2: illegal code / direction pairings
        for (int i = 0; i < 6; i++) begin
            logic [7:0] code;
            logic       dir;
            int r0, w0;
            case (i)
                0: begin code = 8'h00; dir = 1'b0; end
                1: begin code = 8'hC8; dir = 1'b1; end
                2: begin code = 8'hCA; dir = 1'b0; end
                3: begin code = 8'h25; dir = 1'b0; end
                4: begin code = 8'hC9; dir = 1'b1; end
                default: begin code = 8'hFF; dir = 1'b1; end
            endcase
            r0 = rd_cnt; w0 = wr_cnt;
            pulse_start(code, dir);
            check(cpu_irq, "R2 bad command irq", int'(cpu_irq), 1);
            check(cpu_result == 3'd3, "R2 bad command result", int'(cpu_result), 3);
            check(cpu_status == 8'h00, "R2 bad command status", int'(cpu_status), 0);
            @(negedge clk);
            check(rd_cnt == r0 && wr_cnt == w0, "R2 no bus activity", rd_cnt + wr_cnt, r0 + w0);
            clear_irq();
        end

        // R3 R5 R7 R8 R12: every pre-issue status byte, single attempt
        cfg_max_tries = 4'd1;
        for (int s = 0; s < 256; s++) begin
            logic [7:0] st, fin, code;
            logic dir, ready;
            int w0;
            st    = s[7:0];
            dir   = st[4];
            code  = dir ? 8'hCA : 8'hC8;
            fin   = st[1] ? 8'h51 : 8'h50;
            ready = !st[7] && st[6] && !st[3];
            dev_status = st;
            w0 = wr_cnt;
            pulse_start(code, dir);
            check(dev_rd && !dev_reg_sel, "R3 status read after start", int'({dev_rd, dev_reg_sel}), 2);
            check(cpu_busy, "R12 busy after start", int'(cpu_busy), 1);
            @(negedge clk);
            if (!ready) begin
                check(cpu_irq && cpu_result == 3'd2, "R5 not ready result", int'(cpu_result), 2);
                check(cpu_status == st, "R5 not ready status", int'(cpu_status), int'(st));
                clear_irq();
                check(wr_cnt == w0, "R5 no command write", wr_cnt, w0);
            end else begin
                check(dev_wr && dev_reg_sel && dev_wdata == code, "R3 command write",
                      int'(dev_wdata), int'(code));
                @(negedge clk);
                dev_dmarq  = 1'b1;
                burst_idle = 1'b0;
                @(negedge clk);
                check(burst_en && burst_dir == dir, "R7 burst enabled", int'({burst_en, burst_dir}),
                      int'({1'b1, dir}));
                dev_dmarq = 1'b0;
                #1;
                check(!burst_en, "R7 burst follows dmarq", int'(burst_en), 0);
                dev_status = fin;
                dev_intrq  = 1'b1;
                repeat (2) @(negedge clk);
                check(!dev_rd && !cpu_irq, "R8 waits for burst idle", int'({dev_rd, cpu_irq}), 0);
                burst_idle = 1'b1;
                @(negedge clk);
                check(dev_rd && !dev_reg_sel, "R8 final status read", int'(dev_rd), 1);
                dev_intrq = 1'b0;
                @(negedge clk);
                check(cpu_irq && !cpu_busy, "R12 busy ends with irq", int'({cpu_irq, cpu_busy}), 2);
                check(cpu_result == (fin[0] ? 3'd1 : 3'd0), "R8 result from error bit",
                      int'(cpu_result), fin[0] ? 1 : 0);
                check(cpu_status == fin, "R8 captured status", int'(cpu_status), int'(fin));
                check(bad_rd == 0, "R6 no read in data phase", bad_rd, 0);
                if (st == 8'h50) begin
                    int r0;
                    r0 = rd_cnt;
                    pulse_start(8'hC8, 1'b0);
                    @(negedge clk);
                    check(cpu_irq && !cpu_busy && rd_cnt == r0, "R11 start ignored while held",
                          rd_cnt - r0, 0);
                    check(cpu_status == fin, "R11 status held", int'(cpu_status), int'(fin));
                end
                clear_irq();
            end
        end

        // R4 R5: retry count and spacing sweep
        for (int n = 0; n < 4; n++) begin
            for (int g = 0; g < 4; g++) begin
                int r0, w0, exp_rd;
                cfg_max_tries = n[3:0];
                cfg_poll_gap  = g[7:0];
                dev_status    = 8'h80;
                exp_rd        = (n == 0) ? 1 : n;
                r0 = rd_cnt; w0 = wr_cnt;
                pulse_start(8'hCA, 1'b1);
                wait_irq();
                check(rd_cnt - r0 == exp_rd, "R5 attempt count", rd_cnt - r0, exp_rd);
                check(cpu_result == 3'd2 && cpu_status == 8'h80, "R5 not ready after retries",
                      int'(cpu_result), 2);
                if (exp_rd > 1) check(last_gap == g + 2, "R4 retry spacing", last_gap, g + 2);
                clear_irq();
                check(wr_cnt == w0, "R5 no write after retries", wr_cnt, w0);
            end
        end

        // R4: device becomes ready on the second attempt
        begin
            int r0;
            cfg_max_tries = 4'd4;
            cfg_poll_gap  = 8'd1;
            dev_status    = 8'hC0;
            r0 = rd_cnt;
            pulse_start(8'hC8, 1'b0);
            @(negedge clk);
            dev_status = 8'h50;
            for (int k = 0; k < 20 && !dev_wr; k++) @(negedge clk);
            check(dev_wr && rd_cnt - r0 == 2, "R4 ready on retry", rd_cnt - r0, 2);
            check(last_gap == 3, "R4 retry spacing before success", last_gap, 3);
            @(negedge clk);
            dev_intrq = 1'b1;
            wait_irq();
            dev_intrq = 1'b0;
            check(cpu_result == 3'd0, "R8 ok after retry", int'(cpu_result), 0);
            clear_irq();
        end

        // R9: interrupt before any DMA request
        begin
            int b0;
            cfg_max_tries = 4'd1;
            dev_status = 8'h50;
            pulse_start(8'hC8, 1'b0);
            @(negedge clk);
            @(negedge clk);
            dev_status = 8'h51;
            dev_intrq  = 1'b1;
            b0 = burst_cyc;
            @(negedge clk);
            check(dev_rd, "R9 early interrupt read", int'(dev_rd), 1);
            dev_intrq = 1'b0;
            @(negedge clk);
            check(cpu_irq && cpu_result == 3'd1 && cpu_status == 8'h51, "R9 early error completion",
                  int'(cpu_result), 1);
            check(burst_cyc == b0, "R9 burst never enabled", burst_cyc - b0, 0);
            clear_irq();
        end

        // R10: watchdog timing for several windows
        for (int li = 0; li < 3; li++) begin
            int lim, r0;
            lim = (li == 0) ? 0 : (li == 1) ? 3 : 7;
            cfg_wdog_limit = lim[15:0];
            dev_status = 8'h50;
            r0 = rd_cnt;
            pulse_start(8'hCA, 1'b1);
            @(negedge clk);
            repeat (lim + 1) @(negedge clk);
            check(!cpu_irq, "R10 no timeout inside window", int'(cpu_irq), 0);
            @(negedge clk);
            check(cpu_irq && cpu_result == 3'd4, "R10 timeout result", int'(cpu_result), 4);
            check(rd_cnt - r0 == 1, "R10 no status read on timeout", rd_cnt - r0, 1);
            clear_irq();
        end

        // R10: interrupt on the last cycle of the window
        begin
            cfg_wdog_limit = 16'd4;
            dev_status = 8'h50;
            pulse_start(8'hC8, 1'b0);
            @(negedge clk);
            repeat (5) @(negedge clk);
            dev_intrq = 1'b1;
            @(negedge clk);
            check(dev_rd, "R10 last-cycle interrupt accepted", int'(dev_rd), 1);
            dev_intrq = 1'b0;
            @(negedge clk);
            check(cpu_irq && cpu_result == 3'd0, "R10 boundary completes ok", int'(cpu_result), 0);
            clear_irq();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule